// File: doc/BRIEF.md
# Acquisition, Conversion and Readout Sequencer

This block is the digital controller of one front-end chip with 36 channels and a 16-slot event store. It moves through three phases in a fixed order. While acquisition is open, every trigger takes the next free column and stores the current bunch-crossing count and the pattern of channels that fired. A conversion phase then spends a fixed number of cycles on each filled column, standing in for the analog-to-digital step. A readout phase then shifts the stored data out on one serial line. Before any event data it sends the chip's identifier.

Chips are chained. When a chip finishes sending, its end-of-readout pulse becomes the start-readout of the next chip. The data-acquisition system opens acquisition by holding the start-acquisition input high, and closes it by dropping that input. It then pulses start-conversion and, once conversion is over, start-readout. A flag reports a full store, and a sticky flag reports triggers that arrived after the store was full.

Top module: `readout_sequencer`

## Requirements
- R1: While reset is asserted and just after it is released, ramFull, transmitOn, serOut, endRead and chipSat are all low.
- R2: If startAcq is high while the sequencer is idle, acquisition opens on the next clock. It stays open for as long as startAcq stays high. In each open cycle where any bit of trig is set, the next free column stores trig as the hit map and stores the bunch-crossing count (8 bits). The count is the number of open cycles before that one, modulo 256.
- R3: ramFull is high exactly when all 16 columns hold events. It does not change during readout.
- R4: A trigger that arrives while ramFull is high stores nothing and sets chipSat. chipSat stays set until the next acquisition opens, and it clears then.
- R5: startConv has effect only after an acquisition has closed and before that acquisition's data have been converted. Conversion takes CONV_CYCLES clocks per filled column.
- R6: startRead has effect only once conversion is complete. A startRead that arrives earlier does not raise transmitOn.
- R7: On the clock after an accepted startRead, the frame begins on serOut. It opens with the 8-bit chip ID, MSB first. Each filled column follows, oldest first: its 8-bit count MSB first, then its hit map from channel 35 down to channel 0.
- R8: transmitOn is high for exactly the cycles that carry frame bits. serOut is low whenever transmitOn is low.
- R9: endRead is high for one cycle, directly after the last frame bit. The sequencer is then idle and will accept a new acquisition.
- R10: If an acquisition recorded no events, conversion completes at once and the frame consists of the 8-bit chip ID alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startAcq | input | 1 | Opens acquisition from idle; acquisition stays open while this is high |
| startConv | input | 1 | Conversion start pulse |
| startRead | input | 1 | Readout start pulse; also the end-of-readout of the previous chip in the chain |
| trig | input | 36 | Per-channel trigger pattern; any set bit records an event |
| ramFull | output | 1 | All event columns are filled |
| transmitOn | output | 1 | A frame bit is on serOut |
| serOut | output | 1 | Serial frame data |
| endRead | output | 1 | One-cycle pulse after the last frame bit |
| chipSat | output | 1 | A trigger was lost to a full store |

## Verification
The controls, the counters and the store are registered once, and every output is decoded from those registers. A trigger presented in a cycle therefore shows up in ramFull and chipSat at the next clock, and the bench samples these flags at the falling edge that follows that clock. transmitOn and the first frame bit appear at the clock after startRead is sampled, so frame bit k is compared at falling edge k+1 after the pulse. endRead is expected at the falling edge that follows the last bit, and is checked low again one cycle later. Conversion lasts CONV_CYCLES clocks per column. The bench therefore tries startRead during that window to confirm it is rejected, and then waits past the window before starting the readout.

// File: rtl/readout_seq_pkg.sv
package readout_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_HOLD,
    ST_CONV,
    ST_READY,
    ST_SHIFT,
    ST_END
  } seqState_t;

  typedef struct packed {
    logic acqClear;
    logic acqRun;
    logic shiftClear;
    logic shiftStep;
  } seqStrobe_t;

endpackage

// File: rtl/readout_seq_ctrl.sv
module readout_seq_ctrl
  import readout_seq_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int CONV_CYCLES = 4,
  localparam int CNT_W      = $clog2(DEPTH + 1),
  localparam int TMR_W      = $clog2(CONV_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startAcq,
  input  logic             startConv,
  input  logic             startRead,
  input  logic [CNT_W-1:0] colCount,
  input  logic             lastBit,
  output seqStrobe_t       strobe,
  output logic             transmitOn,
  output logic             endRead
);

  seqState_t state, stateNext;
  logic [TMR_W-1:0] convTimer, convTimerNext;
  logic [CNT_W-1:0] convCol, convColNext;

  always_comb begin
    stateNext     = state;
    convTimerNext = convTimer;
    convColNext   = convCol;
    strobe        = '0;
    unique case (state)
      ST_IDLE: if (startAcq) begin
        stateNext       = ST_ACQ;
        strobe.acqClear = 1'b1;
      end
      ST_ACQ: begin
        strobe.acqRun = startAcq;
        if (!startAcq) stateNext = ST_HOLD;
      end
      ST_HOLD: if (startConv) begin
        stateNext     = ST_CONV;
        convTimerNext = '0;
        convColNext   = '0;
      end
      ST_CONV: begin
        if (colCount == '0) begin
          stateNext = ST_READY;
        end else if (convTimer == TMR_W'(CONV_CYCLES - 1)) begin
          convTimerNext = '0;
          if (convCol + 1'b1 == colCount) stateNext = ST_READY;
          else convColNext = convCol + 1'b1;
        end else begin
          convTimerNext = convTimer + 1'b1;
        end
      end
      ST_READY: if (startRead) begin
        stateNext         = ST_SHIFT;
        strobe.shiftClear = 1'b1;
      end
      ST_SHIFT: begin
        strobe.shiftStep = 1'b1;
        if (lastBit) stateNext = ST_END;
      end
      ST_END:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      convTimer <= '0;
      convCol   <= '0;
    end else begin
      state     <= stateNext;
      convTimer <= convTimerNext;
      convCol   <= convColNext;
    end
  end

  assign transmitOn = (state == ST_SHIFT);
  assign endRead    = (state == ST_END);

endmodule

// File: rtl/readout_seq_dp.sv
module readout_seq_dp
  import readout_seq_pkg::*;
#(
  parameter int NUM_CH         = 36,
  parameter int DEPTH          = 16,
  parameter int BCID_W         = 8,
  parameter int HDR_W          = 8,
  parameter logic [HDR_W-1:0] CHIP_ID = 8'hA5,
  localparam int CNT_W         = $clog2(DEPTH + 1),
  localparam int IDX_W         = $clog2(DEPTH),
  localparam int WORD_W        = BCID_W + NUM_CH,
  localparam int POS_W         = $clog2(WORD_W),
  localparam int HPOS_W        = $clog2(HDR_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [NUM_CH-1:0] trig,
  output logic [CNT_W-1:0]  colCount,
  output logic              lastBit,
  output logic              ramFull,
  output logic              chipSat,
  output logic              serOut
);

  logic [BCID_W-1:0] bcidMem [DEPTH];
  logic [NUM_CH-1:0] hitMem  [DEPTH];
  logic [BCID_W-1:0] bcid;
  logic              inHdr;
  logic [POS_W-1:0]  bitPos;
  logic [CNT_W-1:0]  rdCol;
  logic [WORD_W-1:0] dataWord;
  logic [HPOS_W-1:0] hdrIdx;
  logic              hit, store, hdrEnd, wordEnd, curBit;

  assign ramFull = (colCount == CNT_W'(DEPTH));
  assign hit     = strobe.acqRun && (|trig);
  assign store   = hit && !ramFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colCount <= '0;
      bcid     <= '0;
      chipSat  <= 1'b0;
    end else if (strobe.acqClear) begin
      colCount <= '0;
      bcid     <= '0;
      chipSat  <= 1'b0;
    end else if (strobe.acqRun) begin
      bcid <= bcid + 1'b1;
      if (hit && ramFull) chipSat <= 1'b1;
      if (store) colCount <= colCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (store) begin
      bcidMem[colCount[IDX_W-1:0]] <= bcid;
      hitMem[colCount[IDX_W-1:0]]  <= trig;
    end
  end

  assign dataWord = {bcidMem[rdCol[IDX_W-1:0]], hitMem[rdCol[IDX_W-1:0]]};
  assign hdrIdx   = HPOS_W'(HDR_W - 1) - bitPos[HPOS_W-1:0];
  assign hdrEnd   = inHdr && (bitPos == POS_W'(HDR_W - 1));
  assign wordEnd  = !inHdr && (bitPos == POS_W'(WORD_W - 1));
  assign lastBit  = (hdrEnd && colCount == '0) ||
                    (wordEnd && (rdCol + 1'b1 == colCount));
  assign curBit   = inHdr ? CHIP_ID[hdrIdx] : dataWord[POS_W'(WORD_W - 1) - bitPos];
  assign serOut   = strobe.shiftStep && curBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inHdr  <= 1'b1;
      bitPos <= '0;
      rdCol  <= '0;
    end else if (strobe.shiftClear) begin
      inHdr  <= 1'b1;
      bitPos <= '0;
      rdCol  <= '0;
    end else if (strobe.shiftStep) begin
      if (hdrEnd) begin
        inHdr  <= 1'b0;
        bitPos <= '0;
      end else if (wordEnd) begin
        bitPos <= '0;
        rdCol  <= rdCol + 1'b1;
      end else begin
        bitPos <= bitPos + 1'b1;
      end
    end
  end

endmodule

// File: rtl/readout_sequencer.sv
module readout_sequencer
  import readout_seq_pkg::*;
#(
  parameter int NUM_CH      = 36,
  parameter int DEPTH       = 16,
  parameter int BCID_W      = 8,
  parameter int HDR_W       = 8,
  parameter logic [HDR_W-1:0] CHIP_ID = 8'hA5,
  parameter int CONV_CYCLES = 4,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startAcq,
  input  logic              startConv,
  input  logic              startRead,
  input  logic [NUM_CH-1:0] trig,
  output logic              ramFull,
  output logic              transmitOn,
  output logic              serOut,
  output logic              endRead,
  output logic              chipSat
);

  seqStrobe_t       strobe;
  logic [CNT_W-1:0] colCount;
  logic             lastBit;

  readout_seq_ctrl #(.DEPTH(DEPTH), .CONV_CYCLES(CONV_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .startAcq(startAcq), .startConv(startConv),
    .startRead(startRead), .colCount(colCount), .lastBit(lastBit),
    .strobe(strobe), .transmitOn(transmitOn), .endRead(endRead)
  );

  readout_seq_dp #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .BCID_W(BCID_W),
                   .HDR_W(HDR_W), .CHIP_ID(CHIP_ID)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .trig(trig),
    .colCount(colCount), .lastBit(lastBit), .ramFull(ramFull),
    .chipSat(chipSat), .serOut(serOut)
  );

endmodule

// File: rtl/readout_seq_checker.sv
module readout_seq_checker (
  input logic clk,
  input logic rstN,
  input logic startRead,
  input logic ramFull,
  input logic transmitOn,
  input logic serOut,
  input logic endRead,
  input logic chipSat
);

  a_r9_end_single: assert property (@(posedge clk) disable iff (!rstN)
    endRead |=> !endRead);

  a_r9_end_after_tx: assert property (@(posedge clk) disable iff (!rstN)
    $fell(transmitOn) |-> endRead);

  a_r8_quiet_line: assert property (@(posedge clk) disable iff (!rstN)
    !transmitOn |-> !serOut);

  a_r4_sat_only_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chipSat) |-> ramFull);

  a_r6_tx_after_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(transmitOn) |-> $past(startRead));

  a_r3_full_steady_tx: assert property (@(posedge clk) disable iff (!rstN)
    (transmitOn && $past(transmitOn)) |-> $stable(ramFull));

endmodule

bind readout_sequencer readout_seq_checker u_chk (
  .clk(clk), .rstN(rstN), .startRead(startRead), .ramFull(ramFull),
  .transmitOn(transmitOn), .serOut(serOut), .endRead(endRead), .chipSat(chipSat)
);

// File: tb/readout_sequencer_bench.sv
module readout_sequencer_bench;

  localparam int NCH = 36;
  localparam int DEP = 16;
  localparam int CONV = 4;
  localparam logic [7:0] ID = 8'h5C;
  localparam int NEVT = 6;
  // each entry: {idle cycles before the trigger, hit pattern}
  localparam logic [43:0] EVT_TAB [NEVT] = '{
    {8'd0,   36'h0_0000_0001},
    {8'd3,   36'h8_0000_0000},
    {8'd1,   36'hF_0F0F_0F0F},
    {8'd10,  36'h1_2345_6789},
    {8'd0,   36'hA_AAAA_AAAA},
    {8'd250, 36'h0_8000_0400}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic startAcq = 1'b0, startConv = 1'b0, startRead = 1'b0;
  logic [NCH-1:0] trig = '0;
  logic ramFull, transmitOn, serOut, endRead, chipSat;

  int checks = 0, failures = 0, cyc = 0, acqCyc = 0, mCount = 0;
  logic [7:0]     mBcid [DEP];
  logic [NCH-1:0] mHit  [DEP];

  always #2 clk = ~clk;

  readout_sequencer #(.CHIP_ID(ID), .CONV_CYCLES(CONV)) u_readout_sequencer (
    .clk(clk), .rstN(rstN), .startAcq(startAcq), .startConv(startConv),
    .startRead(startRead), .trig(trig), .ramFull(ramFull),
    .transmitOn(transmitOn), .serOut(serOut), .endRead(endRead), .chipSat(chipSat)
  );

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic expBit(input int k);
    logic [43:0] w;
    int j;
    if (k < 8) return ID[7-k];
    j = k - 8;
    w = {mBcid[j/44], mHit[j/44]};
    return w[43 - (j % 44)];
  endfunction

  task automatic startAcquire();
    startAcq = 1'b1;
    @(negedge clk);
    acqCyc = 0;
    mCount = 0;
  endtask

  task automatic pulseTrig(input int gap, input logic [NCH-1:0] hits);
    for (int g = 0; g < gap; g++) begin
      trig = '0;
      @(negedge clk);
      acqCyc++;
    end
    trig = hits;
    if (mCount < DEP) begin
      mBcid[mCount] = 8'(acqCyc);
      mHit[mCount]  = hits;
      mCount++;
    end
    @(negedge clk);
    acqCyc++;
    trig = '0;
  endtask

  task automatic endAcquire();
    startAcq = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(input int which);
    if (which == 0) startConv = 1'b1; else startRead = 1'b1;
    @(negedge clk);
    startConv = 1'b0;
    startRead = 1'b0;
  endtask

  task automatic readAndCheck();
    int n;
    n = 8 + 44 * mCount;
    pulse(1);
    for (int k = 0; k < n; k++) begin
      chk(transmitOn === 1'b1, "R8 transmitOn during frame", transmitOn, 1);
      chk(serOut === expBit(k), "R7 frame bit", serOut, expBit(k));
      @(negedge clk);
    end
    chk(transmitOn === 1'b0, "R8 transmitOn after frame", transmitOn, 0);
    chk(endRead === 1'b1, "R9 endRead after last bit", endRead, 1);
    @(negedge clk);
    chk(endRead === 1'b0, "R9 endRead one cycle", endRead, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({ramFull, transmitOn, serOut, endRead, chipSat} === 5'b0, "R1 reset outputs",
        {ramFull, transmitOn, serOut, endRead, chipSat}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk({ramFull, transmitOn, serOut, endRead, chipSat} === 5'b0, "R1 after release",
        {ramFull, transmitOn, serOut, endRead, chipSat}, 0);

    // R5: startConv from idle is ignored, so a later startRead cannot transmit
    pulse(0);
    repeat (5) @(negedge clk);
    pulse(1);
    chk(transmitOn === 1'b0, "R5 startConv ignored in idle", transmitOn, 0);

    // table-driven run: R2 storage, R7 frame order
    startAcquire();
    for (int e = 0; e < NEVT; e++) pulseTrig(int'(EVT_TAB[e][43:36]), EVT_TAB[e][35:0]);
    endAcquire();
    chk(ramFull === 1'b0, "R3 not full with six events", ramFull, 0);
    pulse(1);
    chk(transmitOn === 1'b0, "R6 startRead ignored before conversion", transmitOn, 0);
    pulse(0);
    pulse(1);
    chk(transmitOn === 1'b0, "R6 startRead ignored during conversion", transmitOn, 0);
    repeat (mCount * CONV + 4) @(negedge clk);
    readAndCheck();

    // overflow: R3 full flag, R4 dropped triggers and saturation
    startAcquire();
    for (int i = 0; i < DEP + 2; i++) begin
      if (i == DEP) chk(chipSat === 1'b0, "R4 chipSat low before overflow", chipSat, 0);
      pulseTrig(1, NCH'(i + 1) * 36'h1_0000_0001 ^ 36'h3_0000_0000);
      if (i == DEP - 2) chk(ramFull === 1'b0, "R3 not full at fifteen", ramFull, 0);
      if (i == DEP - 1) chk(ramFull === 1'b1, "R3 full at sixteen", ramFull, 1);
      if (i == DEP) chk(chipSat === 1'b1, "R4 chipSat on dropped trigger", chipSat, 1);
    end
    endAcquire();
    pulse(0);
    repeat (DEP * CONV + 4) @(negedge clk);
    chk(chipSat === 1'b1, "R4 chipSat held", chipSat, 1);
    readAndCheck();
    chk(ramFull === 1'b1, "R3 full kept after readout", ramFull, 1);

    // R9/R4: new acquisition accepted after readout and clears flags
    startAcquire();
    chk(chipSat === 1'b0, "R4 chipSat cleared by new acquisition", chipSat, 0);
    chk(ramFull === 1'b0, "R2 columns freed by new acquisition", ramFull, 0);
    repeat (4) @(negedge clk);
    endAcquire();
    pulse(0);
    @(negedge clk);
    chk(transmitOn === 1'b0, "R10 idle before read", transmitOn, 0);
    readAndCheck();   // R10: header only

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule